// File: doc/BRIEF.md
# Programmable Tap-Select Timer and Divider

This block is a binary prescaler with one output pin that works either as a divide-by-2^n clock divider or as a one-shot interval timer. The counting event is a single-cycle enable strobe in the system clock domain. No clock is derived from the counter. A two-bit code picks which counter stage drives the output. The low stages can also be skipped, which shortens the chain to its upper part.

In the recycle mode, the selected stage goes straight to the output, so the output is a square wave with a period of 2^n strobes. In the single-cycle mode, a sticky latch sets once the selected stage first goes high, that is after 2^(n-1) strobes. The output then flips once and holds. The latch is rearmed by a master reset, by a power-on reset request that is not masked, or by any change in the level of the mode input. A polarity input sets the output level while the block is cleared, and it inverts the output in both modes. With polarity 1 in the single-cycle mode, each master reset pulse starts a retriggerable high pulse that lasts 2^(n-1) strobes.

Top module: `prog_tap_timer`

## Requirements
- R1: While a clear is active, and on the cycle after a clear, every counter stage is zero and `q_o` equals `pol_i`.
- R2: The counter advances by exactly one step on each clock edge where `cnt_stb_i` is 1 and no clear is active. It holds on every other edge.
- R3: With `sel_i` = 2'b01, the tap is stage TAP_CODE1 (default 10). In recycle mode, `q_o` toggles every 2^(TAP_CODE1-1) strobes.
- R4: With `sel_i` = 2'b00, the tap is stage TAP_CODE0 (default 13). In recycle mode, `q_o` toggles every 2^(TAP_CODE0-1) strobes.
- R5: With `sel_i` = 2'b11, the tap is the top stage, stage STAGES. In recycle mode, `q_o` toggles every 2^(STAGES-1) strobes.
- R6: With `sel_i` = 2'b10, the tap is still the top stage, but each strobe goes directly into stage SKIP_STAGES+1 and the low stages freeze. `q_o` toggles every 2^(STAGES-SKIP_STAGES-1) strobes.
- R7: With `mode_i` = 0 (single cycle), `q_o` equals `pol_i` until the selected stage first goes high. After that it equals the inverse of `pol_i` and holds until the next clear, even if the counter wraps.
- R8: A change in the level of `mode_i` is a clear. It is active in the cycle where the new level first appears.
- R9: `mr_i` = 1 is a clear. Strobes that arrive while it is held are discarded, and counting starts from zero after it is released.
- R10: `por_req_i` = 1 is a clear only when `por_mask_i` = 0. When `por_mask_i` = 1, the request has no effect on the count or on the output.
- R11: A change of `sel_i` without a clear keeps the count. The newly selected stage drives `q_o` in the same cycle.
- R12: `pol_i` = 1 inverts `q_o` in both modes. In recycle mode, `q_o` equals the tapped stage XOR `pol_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cnt_stb_i | input | 1 | Count strobe, one counting event per high cycle |
| mr_i | input | 1 | Master reset, active high, synchronous clear |
| por_req_i | input | 1 | Power-on reset request pulse |
| por_mask_i | input | 1 | 1 blocks power-on reset requests |
| sel_i | input | 2 | Tap select code: 00, 01, 10 (skip low stages), 11 |
| mode_i | input | 1 | 1 selects recycle (divider), 0 selects single cycle (timer) |
| pol_i | input | 1 | Output level while cleared, and output inversion |
| q_o | output | 1 | Timer or divider output |

## Verification
The bench sweeps every combination of mode, polarity and select code on a reduced six-stage counter. The strobe runs back to back in some sweeps and every other cycle in others. Each cycle is compared against an arithmetic count model. The sweeps run well past a full wrap of the counter. A design that let the single-cycle latch fall again would show a second edge after the wrap. A skip path that still waited for the low stages to carry would run four times too slow on code 10. Directed sequences then target the rest. They drive strobes while master reset is held, where a design that leaked them would start from a nonzero count. They flip the mode level in the middle of a count, where a design without edge detection would keep its stale latch. They send a power-on request while it is masked, which a design without gating would treat as a clear. They also change the select code without a clear, where a design that cleared on that change would restart the interval.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Select codes. Bit 1 forces the top stage, and bit 0 = 0 under it skips
   // the low stages.
   typedef enum logic [1:0] {
      SEL_MID_HI   = 2'b00,
      SEL_MID_LO   = 2'b01,
      SEL_TOP_SKIP = 2'b10,
      SEL_TOP      = 2'b11
   } tap_sel_e;

   localparam logic MODE_SINGLE  = 1'b0;
   localparam logic MODE_RECYCLE = 1'b1;

   function automatic logic sel_skips_low(input logic [1:0] code);
      return code == SEL_TOP_SKIP;
   endfunction

   function automatic logic sel_forces_top(input logic [1:0] code);
      return code[1];
   endfunction

endpackage

// File: rtl/tmr_reset_ctl.sv
module tmr_reset_ctl #(
   parameter bit POR_GATED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mr_i,
   input  logic por_req_i,
   input  logic por_mask_i,
   input  logic mode_i,
   output logic clear_o
);

   logic mode_q;
   logic mode_flip;
   logic por_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= tmr_pkg::MODE_SINGLE;
      end else begin
         mode_q <= mode_i;
      end
   end

   assign mode_flip = mode_i ^ mode_q;

   generate
      if (POR_GATED) begin : g_por_gated
         assign por_hit = por_req_i & ~por_mask_i;
      end else begin : g_por_always
         assign por_hit = por_req_i;
      end
   endgenerate

   assign clear_o = mr_i | por_hit | mode_flip;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int STAGES             = 16,
   parameter int SKIP_STAGES        = 8,
   parameter bit FREEZE_LOW_ON_SKIP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              stb_i,
   input  logic              skip_i,
   output logic [STAGES-1:0] cnt_o
);

   localparam int HI_W = STAGES - SKIP_STAGES;
   localparam logic [STAGES-1:0] ONE_FULL = {{(STAGES-1){1'b0}}, 1'b1};
   localparam logic [HI_W-1:0]   ONE_HI   = {{(HI_W-1){1'b0}}, 1'b1};

   generate
      if (SKIP_STAGES < 1 || SKIP_STAGES >= STAGES) begin : g_bad_skip
         $error("tmr_prescaler: SKIP_STAGES must lie in 1..STAGES-1");
      end
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_prescaler: STAGES must be at least 2");
      end
   endgenerate

   logic [SKIP_STAGES-1:0] low_q;
   logic [HI_W-1:0]        high_q;
   logic                   run;
   logic                   low_carry;
   logic                   adv_low;
   logic                   adv_high;

   assign run       = stb_i & ~clear_i;
   assign low_carry = &low_q;

   generate
      if (FREEZE_LOW_ON_SKIP) begin : g_low_freeze
         assign adv_low = run & ~skip_i;
      end else begin : g_low_free
         assign adv_low = run;
      end
   endgenerate

   assign adv_high = run & (skip_i | low_carry);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
      end else if (clear_i) begin
         low_q <= '0;
      end else if (adv_low) begin
         low_q <= low_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_q <= '0;
      end else if (clear_i) begin
         high_q <= '0;
      end else if (adv_high) begin
         high_q <= high_q + ONE_HI;
      end
   end

   assign cnt_o = {high_q, low_q};

   // R1 / R9: a clear leaves every stage at zero
   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_o == '0));

   // R2: no strobe, no movement
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_i && !clear_i) |=> $stable(cnt_o));

   // R2: a strobe on the full chain is a single increment
   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && !clear_i && !skip_i) |=> (cnt_o == $past(cnt_o) + ONE_FULL));

   // R6: on the skip path the upper part moves on every strobe
   a_r6_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && !clear_i && skip_i) |=>
         (cnt_o[STAGES-1:SKIP_STAGES] == $past(cnt_o[STAGES-1:SKIP_STAGES]) + ONE_HI));

endmodule

// File: rtl/tmr_tap_mux.sv
module tmr_tap_mux #(
   parameter int STAGES    = 16,
   parameter int TAP_CODE0 = 13,
   parameter int TAP_CODE1 = 10
) (
   input  logic [STAGES-1:0] cnt_i,
   input  logic [1:0]        sel_i,
   output logic              tap_o
);

   localparam int IDX0   = TAP_CODE0 - 1;
   localparam int IDX1   = TAP_CODE1 - 1;
   localparam int IDXTOP = STAGES - 1;

   generate
      if (TAP_CODE0 < 1 || TAP_CODE0 > STAGES) begin : g_bad_tap0
         $error("tmr_tap_mux: TAP_CODE0 out of range");
      end
      if (TAP_CODE1 < 1 || TAP_CODE1 > STAGES) begin : g_bad_tap1
         $error("tmr_tap_mux: TAP_CODE1 out of range");
      end
   endgenerate

   always_comb begin
      if (tmr_pkg::sel_forces_top(sel_i)) begin
         tap_o = cnt_i[IDXTOP];
      end else if (sel_i[0]) begin
         tap_o = cnt_i[IDX1];
      end else begin
         tap_o = cnt_i[IDX0];
      end
   end

endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic mode_i,
   input  logic pol_i,
   input  logic tap_i,
   output logic q_o
);

   logic latch_q;
   logic level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
      end else if (clear_i) begin
         latch_q <= 1'b0;
      end else if (mode_i == tmr_pkg::MODE_SINGLE && tap_i) begin
         latch_q <= 1'b1;
      end
   end

   always_comb begin
      if (mode_i == tmr_pkg::MODE_RECYCLE) begin
         level = tap_i;
      end else begin
         level = latch_q | tap_i;
      end
   end

   assign q_o = clear_i ? pol_i : (level ^ pol_i);

   // R7: once set, the latch stays set until a clear
   a_r7_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !clear_i) |=> latch_q);

   // R7: after the single transition the unpolarised output is frozen
   a_r7_single_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == tmr_pkg::MODE_SINGLE && latch_q && !clear_i) |=>
         (clear_i || mode_i || ((q_o ^ pol_i) == ($past(q_o) ^ $past(pol_i)))));

endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer #(
   parameter int STAGES             = 16,
   parameter int SKIP_STAGES        = 8,
   parameter int TAP_CODE0          = 13,
   parameter int TAP_CODE1          = 10,
   parameter bit FREEZE_LOW_ON_SKIP = 1'b1,
   parameter bit POR_GATED          = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnt_stb_i,
   input  logic       mr_i,
   input  logic       por_req_i,
   input  logic       por_mask_i,
   input  logic [1:0] sel_i,
   input  logic       mode_i,
   input  logic       pol_i,
   output logic       q_o
);

   logic              clear;
   logic              skip;
   logic              tap;
   logic [STAGES-1:0] cnt;

   assign skip = tmr_pkg::sel_skips_low(sel_i);

   tmr_reset_ctl #(
      .POR_GATED (POR_GATED)
   ) u_reset (
      .clk        (clk),
      .rst_n      (rst_n),
      .mr_i       (mr_i),
      .por_req_i  (por_req_i),
      .por_mask_i (por_mask_i),
      .mode_i     (mode_i),
      .clear_o    (clear)
   );

   tmr_prescaler #(
      .STAGES             (STAGES),
      .SKIP_STAGES        (SKIP_STAGES),
      .FREEZE_LOW_ON_SKIP (FREEZE_LOW_ON_SKIP)
   ) u_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .stb_i   (cnt_stb_i),
      .skip_i  (skip),
      .cnt_o   (cnt)
   );

   tmr_tap_mux #(
      .STAGES    (STAGES),
      .TAP_CODE0 (TAP_CODE0),
      .TAP_CODE1 (TAP_CODE1)
   ) u_tap_mux (
      .cnt_i (cnt),
      .sel_i (sel_i),
      .tap_o (tap)
   );

   tmr_out_ctl u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .mode_i  (mode_i),
      .pol_i   (pol_i),
      .tap_i   (tap),
      .q_o     (q_o)
   );

   // R8: a fresh mode level clears the counter in the cycle it appears
   a_r8_mode_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (mode_i != $past(mode_i))) |-> clear);

   // R9: while master reset is held, the count sits at zero
   a_r9_mr_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_i && $past(mr_i)) |-> (cnt == '0));

endmodule

// File: tb/prog_tap_timer_tb.sv
module prog_tap_timer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ST = 6;
   localparam int BY = 2;
   localparam int T0 = 5;
   localparam int T1 = 3;
   localparam int WRAP = 1 << ST;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stb = 1'b0;
   logic       mr = 1'b0;
   logic       por = 1'b0;
   logic       por_mask = 1'b0;
   logic       mode = 1'b0;
   logic       pol = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       q;

   int checks = 0;
   int failures = 0;

   int unsigned c_m = 0;
   bit          lat_m = 1'b0;
   bit          mode_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_tap_timer #(
      .STAGES      (ST),
      .SKIP_STAGES (BY),
      .TAP_CODE0   (T0),
      .TAP_CODE1   (T1)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_stb_i  (stb),
      .mr_i       (mr),
      .por_req_i  (por),
      .por_mask_i (por_mask),
      .sel_i      (sel),
      .mode_i     (mode),
      .pol_i      (pol),
      .q_o        (q)
   );

   function automatic bit tap_m(input logic [1:0] s, input int unsigned c);
      case (s)
         2'b00:   return ((c >> (T0-1)) & 1) != 0;
         2'b01:   return ((c >> (T1-1)) & 1) != 0;
         default: return ((c >> (ST-1)) & 1) != 0;
      endcase
   endfunction

   function automatic bit clear_m();
      return mr || (por && !por_mask) || (mode != mode_prev);
   endfunction

   function automatic logic exp_m();
      bit t;
      t = tap_m(sel, c_m);
      if (clear_m()) return pol;
      return (mode ? t : (lat_m | t)) ^ pol;
   endfunction

   task automatic model_edge();
      if (clear_m()) begin
         c_m = 0;
         lat_m = 1'b0;
      end else begin
         if (!mode && tap_m(sel, c_m)) lat_m = 1'b1;
         if (stb) begin
            if (sel == 2'b10) c_m = (c_m + (1 << BY)) % WRAP;
            else              c_m = (c_m + 1) % WRAP;
         end
      end
      mode_prev = mode;
   endtask

   task automatic check(input string tag, input logic exp);
      checks++;
      if (q !== exp) begin
         failures++;
         $display("FAIL %s: q=%0b expected=%0b (count model %0d)", tag, q, exp, c_m);
      end
   endtask

   task automatic cyc(input logic s, input logic m, input string tag);
      stb = s;
      mr  = m;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag, exp_m());
   endtask

   function automatic string sweep_tag(input logic md, input logic [1:0] s);
      if (!md) return "R7 single";
      case (s)
         2'b00:   return "R4 tap00";
         2'b01:   return "R3 tap01 R2";
         2'b10:   return "R6 skip";
         default: return "R5 top";
      endcase
   endfunction

   function automatic int half_of(input logic [1:0] s);
      case (s)
         2'b00:   return 1 << (T0-1);
         2'b01:   return 1 << (T1-1);
         2'b10:   return 1 << (ST-BY-1);
         default: return 1 << (ST-1);
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset state", 1'b0);

      // Sweeps: every mode, polarity and select code
      for (int md = 0; md < 2; md++) begin
         for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 4; s++) begin
               mode = md[0];
               pol  = p[0];
               sel  = s[1:0];
               cyc(1'b1, 1'b1, "R1 R12 clear level");
               cyc(1'b0, 1'b0, "R1 after clear");
               for (int i = 0; i < 2 * (4 * half_of(s[1:0]) + 2); i++) begin
                  if (s[0]) cyc(i[0], 1'b0, sweep_tag(md[0], s[1:0]));
                  else if (i < 4 * half_of(s[1:0]) + 2)
                     cyc(1'b1, 1'b0, sweep_tag(md[0], s[1:0]));
               end
            end
         end
      end

      // R9: strobes under held master reset are dropped
      mode = 1'b1; pol = 1'b0; sel = 2'b01;
      cyc(1'b0, 1'b0, "R8 mode level settle");
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, "R9 held reset");
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R9 count from zero");
      check("R9 divider high after four", 1'b1);

      // R10: masked request is ignored, unmasked one clears
      por = 1'b1; por_mask = 1'b1;
      cyc(1'b1, 1'b0, "R10 masked request");
      check("R10 masked keeps count", 1'b1);
      por_mask = 1'b0;
      cyc(1'b0, 1'b0, "R10 unmasked request");
      por = 1'b0;
      cyc(1'b0, 1'b0, "R10 after request");
      check("R10 cleared output", 1'b0);

      // R11: select change keeps the count
      cyc(1'b1, 1'b1, "R11 clear");
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R11 count");
      sel = 2'b00;
      #1 check("R11 new tap same cycle", exp_m());
      for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, "R11 continue");
      check("R11 stage five reached", 1'b1);

      // R8: mode flip mid count rearms the single-cycle latch
      mode = 1'b0; sel = 2'b01; pol = 1'b1;
      cyc(1'b0, 1'b1, "R8 clear");
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, "R7 R12 one-shot");
      check("R7 one-shot expired", 1'b0);
      mode = 1'b1;
      #1 check("R8 flip clears now", 1'b1);
      cyc(1'b1, 1'b0, "R8 flip edge");
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R8 recount");
      check("R8 recount toggled", 1'b0);
      mode = 1'b0;
      #1 check("R8 flip back clears", 1'b1);
      cyc(1'b0, 1'b0, "R8 flip back edge");

      // R7: retrigger of the one-shot
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, "R7 hold low");
      check("R7 held low past wrap", 1'b0);
      cyc(1'b0, 1'b1, "R7 retrigger");
      cyc(1'b0, 1'b0, "R7 retrigger high");
      check("R7 high after retrigger", 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule